// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus master and judges every access it makes. Each access carries an address, a write flag, an instruction-fetch flag and a privilege flag. The block compares the address against a table of programmable regions. One cycle later it answers with either a grant or a fault. With a grant it also returns the memory attributes of the matching region: shareable, cacheable, bufferable and a three-bit type field. When several regions contain the address, the highest-numbered one decides. Addresses that fall in no region may optionally use a background map that only privileged accesses can use.

Software programs the table indirectly through a word-wide register port. It writes a region number into a select register. Writes to the base and attribute registers then land in that region. Last, it sets the global enable bit. Only aligned full-word accesses to the register port are accepted; any other access changes nothing and raises an error pulse. The address of the first faulting access is kept in a status register until software clears it.

Top module: `rgn_prot_top`

## Requirements
- R1: After reset the checker is disabled and the default-map bit is clear. The select register and every region field read zero. No fault is pending, and every access is granted with rsp_hit low.
- R2: Register word offsets are: 0x00 control (bit0 enable, bit1 default-map), 0x04 select, 0x08 base, 0x0C attributes, 0x10 status (bit0 fault pending), 0x14 fault address. Writes to 0x08 and 0x0C go to the region held in the select register. Reads of 0x08 and 0x0C return that same region. Base reads return bits [31:5] as written, with bits [4:0] reading zero.
- R3: Attribute bit0 enables a region. The 5-bit SIZE field at bits [5:1] gives a region of 2^(SIZE+1) bytes, and SIZE values below 4 act as 4 (32 bytes). The region's base is the written base with all bits below the region size ignored. SIZE 31 covers the whole 4 GiB map.
- R4: When several enabled regions contain an address, the highest-numbered one supplies the permissions, the attributes and rsp_region. Disabled regions never match.
- R5: AP, at attribute bits [10:8], grants rights as follows: 1 gives privileged read/write only; 2 gives privileged read/write and unprivileged read; 3 gives full read/write; 5 gives privileged read only; 6 and 7 give read-only to both levels; 0 and 4 allow nothing. An instruction fetch counts as a read.
- R6: An instruction fetch from a matched region whose XN bit (attribute bit 12) is set always faults, whatever its AP value.
- R7: On a region match with the checker enabled, rsp_s, rsp_c, rsp_b and rsp_tex return attribute bits 13, 14, 15 and [18:16] of that region. Otherwise they return zero.
- R8: While the control enable bit is clear, every access is granted.
- R9: While enabled, an access that matches no region is granted only if it is privileged and the default-map bit is set; otherwise it faults.
- R10: The response appears exactly one cycle after an access. rsp_valid is high only in that cycle, and while it is high exactly one of rsp_grant and rsp_fault is high.
- R11: The register port accepts only cfg_size = 2 (word) at a word-aligned offset of 0x00 to 0x14. Any other access leaves all state unchanged and pulses cfg_err in the following cycle. Read data appears on cfg_rdata the cycle after the read.
- R12: A fault with no fault pending sets the pending bit and records the faulting address. Further faults leave the recorded address unchanged. A word write to 0x10 clears the pending bit, after which the next fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Response for last cycle's access |
| rsp_grant | output | 1 | Access may proceed |
| rsp_fault | output | 1 | Memory-management fault, access blocked |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | $clog2(NUM_RGN) | Number of the deciding region |
| rsp_s | output | 1 | Shareable attribute |
| rsp_c | output | 1 | Cacheable attribute |
| rsp_b | output | 1 | Bufferable attribute |
| rsp_tex | output | 3 | Type extension attribute |
| cfg_valid | input | 1 | Register access request |
| cfg_write | input | 1 | Register access is a write |
| cfg_offset | input | 5 | Register byte offset |
| cfg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the read |
| cfg_err | output | 1 | Rejected register access, one cycle after |

## Verification
The bench builds the block with its default of eight regions. At that size, every one of the 256 region-enable subsets can be tried over a single address, which proves the highest-number rule and the attribute outputs for every mix of overlaps. The eight AP codes are swept against XN, the two privilege levels and all three access kinds, for 96 cases in all. Region sizes from the clamped minimum up to 32 KiB are probed at both edges and one byte outside, and the whole-map size is checked as well. The checks also cover the default-map matrix, rejected register accesses and the rule that keeps the first faulting address.

// File: rtl/rgn_prot_pkg.sv
package rgn_prot_pkg;

    localparam int unsigned MIN_SZ = 4;   // smallest SIZE code honoured (32 bytes)
    localparam int unsigned BASE_W = 27;  // base bits [31:5]

    typedef struct packed {
        logic              en;
        logic [4:0]        size;
        logic [2:0]        ap;
        logic              xn;
        logic              s;
        logic              c;
        logic              b;
        logic [2:0]        tex;
        logic [BASE_W-1:0] base;
    } rgn_cfg_t;

    typedef struct packed {
        logic       s;
        logic       c;
        logic       b;
        logic [2:0] tex;
    } mem_attr_t;

    // Rights granted by an AP code for one access level and direction.
    function automatic logic ap_allows(logic [2:0] ap, logic priv, logic write);
        logic ok;
        case (ap)
            3'd1:       ok = priv;
            3'd2:       ok = priv | ~write;
            3'd3:       ok = 1'b1;
            3'd5:       ok = priv & ~write;
            3'd6, 3'd7: ok = ~write;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rgn_prot_regs.sv
module rgn_prot_regs
    import rgn_prot_pkg::*;
#(
    parameter int unsigned NUM_RGN = 8,
    localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_valid,
    input  logic                       cfg_write,
    input  logic [4:0]                 cfg_offset,
    input  logic [1:0]                 cfg_size,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    output logic                       cfg_err,
    input  logic                       flt_evt,
    input  logic [31:0]                flt_addr,
    output logic                       ctl_en,
    output logic                       ctl_dflt,
    output rgn_cfg_t [NUM_RGN-1:0]     rgn_tab,
    output logic                       flt_pend,
    output logic                       flt_clr
);

    localparam logic [2:0] W_CTRL  = 3'd0;
    localparam logic [2:0] W_SEL   = 3'd1;
    localparam logic [2:0] W_BASE  = 3'd2;
    localparam logic [2:0] W_ATTR  = 3'd3;
    localparam logic [2:0] W_STAT  = 3'd4;
    localparam logic [2:0] W_FADDR = 3'd5;

    typedef struct packed {
        logic                   en;
        logic                   dflt;
        logic [IDX_W-1:0]       sel;
        rgn_cfg_t [NUM_RGN-1:0] tab;
        logic                   pend;
        logic [31:0]            faddr;
        logic [31:0]            rdata;
        logic                   err;
    } regs_t;

    regs_t      st_d, st_q;
    logic [2:0] widx;
    logic       legal;
    logic       clr;
    logic [31:0] rd_word;
    rgn_cfg_t    cur;

    always_comb begin
        widx  = cfg_offset[4:2];
        legal = (cfg_size == 2'd2) && (cfg_offset[1:0] == 2'b00) && (widx <= W_FADDR);
        cur   = st_q.tab[st_q.sel];

        rd_word = '0;
        case (widx)
            W_CTRL:  rd_word = {30'd0, st_q.dflt, st_q.en};
            W_SEL:   rd_word = 32'(st_q.sel);
            W_BASE:  rd_word = {cur.base, 5'd0};
            W_ATTR:  begin
                rd_word[0]     = cur.en;
                rd_word[5:1]   = cur.size;
                rd_word[10:8]  = cur.ap;
                rd_word[12]    = cur.xn;
                rd_word[13]    = cur.s;
                rd_word[14]    = cur.c;
                rd_word[15]    = cur.b;
                rd_word[18:16] = cur.tex;
            end
            W_STAT:  rd_word = {31'd0, st_q.pend};
            W_FADDR: rd_word = st_q.faddr;
            default: rd_word = '0;
        endcase

        st_d     = st_q;
        st_d.err = 1'b0;
        clr      = 1'b0;
        if (cfg_valid) begin
            if (!legal) begin
                st_d.err = 1'b1;
            end else if (cfg_write) begin
                case (widx)
                    W_CTRL: begin
                        st_d.en   = cfg_wdata[0];
                        st_d.dflt = cfg_wdata[1];
                    end
                    W_SEL:  st_d.sel = cfg_wdata[IDX_W-1:0];
                    W_BASE: st_d.tab[st_q.sel].base = cfg_wdata[31:5];
                    W_ATTR: begin
                        st_d.tab[st_q.sel].en   = cfg_wdata[0];
                        st_d.tab[st_q.sel].size = cfg_wdata[5:1];
                        st_d.tab[st_q.sel].ap   = cfg_wdata[10:8];
                        st_d.tab[st_q.sel].xn   = cfg_wdata[12];
                        st_d.tab[st_q.sel].s    = cfg_wdata[13];
                        st_d.tab[st_q.sel].c    = cfg_wdata[14];
                        st_d.tab[st_q.sel].b    = cfg_wdata[15];
                        st_d.tab[st_q.sel].tex  = cfg_wdata[18:16];
                    end
                    W_STAT: clr = 1'b1;
                    default: ;
                endcase
            end else begin
                st_d.rdata = rd_word;
            end
        end

        if (clr) begin
            st_d.pend = 1'b0;
        end
        if (flt_evt && (!st_q.pend || clr)) begin
            st_d.pend  = 1'b1;
            st_d.faddr = flt_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_rdata = st_q.rdata;
    assign cfg_err   = st_q.err;
    assign ctl_en    = st_q.en;
    assign ctl_dflt  = st_q.dflt;
    assign rgn_tab   = st_q.tab;
    assign flt_pend  = st_q.pend;
    assign flt_clr   = clr;

endmodule

// File: rtl/rgn_prot_lookup.sv
module rgn_prot_lookup
    import rgn_prot_pkg::*;
#(
    parameter int unsigned NUM_RGN = 8,
    localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
    input  logic [31:0]            addr,
    input  rgn_cfg_t [NUM_RGN-1:0] rgn_tab,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx,
    output logic [2:0]             ap,
    output logic                   xn,
    output mem_attr_t              attr
);

    logic [NUM_RGN-1:0] match;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        logic [4:0]  sz_eff;
        logic [5:0]  sh;
        logic [32:0] span;
        logic [32:0] low;
        logic [31:0] keep;

        assign sz_eff   = (rgn_tab[g].size < 5'(MIN_SZ)) ? 5'(MIN_SZ) : rgn_tab[g].size;
        assign sh       = {1'b0, sz_eff} + 6'd1;
        assign span     = 33'd1 << sh;
        assign low      = span - 33'd1;
        assign keep     = ~low[31:0];
        assign match[g] = rgn_tab[g].en &&
                          (((addr ^ {rgn_tab[g].base, 5'd0}) & keep) == 32'd0);
    end

    // Later (higher-numbered) matches overwrite earlier ones.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    assign ap   = rgn_tab[idx].ap;
    assign xn   = rgn_tab[idx].xn;
    assign attr = '{s: rgn_tab[idx].s, c: rgn_tab[idx].c,
                    b: rgn_tab[idx].b, tex: rgn_tab[idx].tex};

endmodule

// File: rtl/rgn_prot_perm.sv
module rgn_prot_perm
    import rgn_prot_pkg::*;
(
    input  logic       en,
    input  logic       dflt,
    input  logic       hit,
    input  logic [2:0] ap,
    input  logic       xn,
    input  logic       write,
    input  logic       fetch,
    input  logic       priv,
    output logic       grant
);

    always_comb begin
        if (!en) begin
            grant = 1'b1;
        end else if (!hit) begin
            grant = priv & dflt;
        end else if (fetch && xn) begin
            grant = 1'b0;
        end else begin
            grant = ap_allows(ap, priv, write & ~fetch);
        end
    end

endmodule

// File: rtl/rgn_prot_top.sv
module rgn_prot_top
    import rgn_prot_pkg::*;
#(
    parameter int unsigned NUM_RGN = 8,
    localparam int unsigned IDX_W = $clog2(NUM_RGN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [31:0]      acc_addr,
    input  logic             acc_write,
    input  logic             acc_fetch,
    input  logic             acc_priv,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_fault,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_region,
    output logic             rsp_s,
    output logic             rsp_c,
    output logic             rsp_b,
    output logic [2:0]       rsp_tex,
    input  logic             cfg_valid,
    input  logic             cfg_write,
    input  logic [4:0]       cfg_offset,
    input  logic [1:0]       cfg_size,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             cfg_err
);

    typedef struct packed {
        logic             valid;
        logic             grant;
        logic             fault;
        logic             hit;
        logic [IDX_W-1:0] idx;
        mem_attr_t        attr;
        logic [31:0]      addr;
    } rsp_t;

    rsp_t                   rsp_d, rsp_q;
    logic                   ctl_en, ctl_dflt;
    rgn_cfg_t [NUM_RGN-1:0] rgn_tab;
    logic                   flt_pend, flt_clr;
    logic                   lk_hit;
    logic [IDX_W-1:0]       lk_idx;
    logic [2:0]             lk_ap;
    logic                   lk_xn;
    mem_attr_t              lk_attr;
    logic                   pm_grant;

    rgn_prot_regs #(.NUM_RGN(NUM_RGN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_valid  (cfg_valid),
        .cfg_write  (cfg_write),
        .cfg_offset (cfg_offset),
        .cfg_size   (cfg_size),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .flt_evt    (rsp_q.valid & rsp_q.fault),
        .flt_addr   (rsp_q.addr),
        .ctl_en     (ctl_en),
        .ctl_dflt   (ctl_dflt),
        .rgn_tab    (rgn_tab),
        .flt_pend   (flt_pend),
        .flt_clr    (flt_clr)
    );

    rgn_prot_lookup #(.NUM_RGN(NUM_RGN)) u_lookup (
        .addr    (acc_addr),
        .rgn_tab (rgn_tab),
        .hit     (lk_hit),
        .idx     (lk_idx),
        .ap      (lk_ap),
        .xn      (lk_xn),
        .attr    (lk_attr)
    );

    rgn_prot_perm u_perm (
        .en    (ctl_en),
        .dflt  (ctl_dflt),
        .hit   (lk_hit),
        .ap    (lk_ap),
        .xn    (lk_xn),
        .write (acc_write),
        .fetch (acc_fetch),
        .priv  (acc_priv),
        .grant (pm_grant)
    );

    always_comb begin
        rsp_d = '0;
        if (acc_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.grant = pm_grant;
            rsp_d.fault = ~pm_grant;
            rsp_d.addr  = acc_addr;
            if (ctl_en && lk_hit) begin
                rsp_d.hit  = 1'b1;
                rsp_d.idx  = lk_idx;
                rsp_d.attr = lk_attr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_grant  = rsp_q.grant;
    assign rsp_fault  = rsp_q.fault;
    assign rsp_hit    = rsp_q.hit;
    assign rsp_region = rsp_q.idx;
    assign rsp_s      = rsp_q.attr.s;
    assign rsp_c      = rsp_q.attr.c;
    assign rsp_b      = rsp_q.attr.b;
    assign rsp_tex    = rsp_q.attr.tex;

endmodule

// File: rtl/rgn_prot_sva.sv
module rgn_prot_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic       acc_fetch,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       rsp_fault,
    input logic       ctl_en,
    input logic       lk_hit,
    input logic       lk_xn,
    input logic       cfg_valid,
    input logic [1:0] cfg_size,
    input logic       cfg_err,
    input logic       flt_pend,
    input logic       flt_clr
);

    assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_fault));

    assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    assert_no_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    assert_off_grants_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctl_en) |=> rsp_grant);

    assert_xn_fetch_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_en && acc_fetch && lk_hit && lk_xn) |=> rsp_fault);

    assert_bad_size_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_size != 2'd2) |=> cfg_err);

    assert_pend_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_pend && !flt_clr) |=> flt_pend);

endmodule

bind rgn_prot_top rgn_prot_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_fetch (acc_fetch),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_fault (rsp_fault),
    .ctl_en    (ctl_en),
    .lk_hit    (lk_hit),
    .lk_xn     (lk_xn),
    .cfg_valid (cfg_valid),
    .cfg_size  (cfg_size),
    .cfg_err   (cfg_err),
    .flt_pend  (flt_pend),
    .flt_clr   (flt_clr)
);

// File: tb/sim_rgn_prot_top.sv
module sim_rgn_prot_top;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        rsp_valid, rsp_grant, rsp_fault, rsp_hit, rsp_s, rsp_c, rsp_b;
    logic [2:0]  rsp_region;
    logic [2:0]  rsp_tex;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0;
    logic [4:0]  cfg_offset = '0;
    logic [1:0]  cfg_size = 2'd2;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rgn_prot_top #(.NUM_RGN(NR)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_op(input logic wr, input logic [4:0] ofs, input logic [1:0] sz,
                          input logic [31:0] d, output logic [31:0] rd, output logic er);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_write = wr; cfg_offset = ofs; cfg_size = sz; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 1'b0;
        rd = cfg_rdata;
        er = cfg_err;
    endtask

    task automatic wr(input logic [4:0] ofs, input logic [31:0] d);
        logic [31:0] r; logic e;
        cfg_op(1'b1, ofs, 2'd2, d, r, e);
    endtask

    task automatic rd(input logic [4:0] ofs, output logic [31:0] d);
        logic e;
        cfg_op(1'b0, ofs, 2'd2, 32'd0, d, e);
    endtask

    task automatic acc(input logic [31:0] a, input logic w, input logic f, input logic p);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    function automatic logic [31:0] mk_attr(int en, int sz, int ap, int xn, int s, int c, int b, int tex);
        logic [31:0] w = '0;
        w[0] = en[0]; w[5:1] = sz[4:0]; w[10:8] = ap[2:0]; w[12] = xn[0];
        w[13] = s[0]; w[14] = c[0]; w[15] = b[0]; w[18:16] = tex[2:0];
        return w;
    endfunction

    // Rights per AP code: {priv read, priv write, user read, user write}
    function automatic bit ap_ok(int ap, bit priv, bit w);
        bit [3:0] t;
        case (ap)
            1: t = 4'b1100;
            2: t = 4'b1110;
            3: t = 4'b1111;
            5: t = 4'b1000;
            6, 7: t = 4'b1010;
            default: t = 4'b0000;
        endcase
        return priv ? (w ? t[2] : t[3]) : (w ? t[0] : t[1]);
    endfunction

    task automatic sel_base_attr(input int r, input logic [31:0] base, input logic [31:0] attr);
        wr(5'h04, r);
        wr(5'h08, base);
        wr(5'h0C, attr);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] d2;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // ---- R1 reset state
        rd(5'h00, d); chk("R1 ctrl", d, 0);
        rd(5'h04, d); chk("R1 sel", d, 0);
        rd(5'h0C, d); chk("R1 attr", d, 0);
        rd(5'h10, d); chk("R1 pending", d, 0);
        acc(32'h1234_5678, 1'b1, 1'b0, 1'b0);
        chk("R1 grant", {rsp_valid, rsp_grant, rsp_fault, rsp_hit}, 4'b1100);

        // ---- R2 indirect programming, readback per region
        for (int i = 0; i < NR; i++)
            sel_base_attr(i, 32'h0100_0000 * (i + 1) + 32'h3F, mk_attr(0, i + 3, i, i & 1, 1, 0, 1, i));
        for (int i = 0; i < NR; i++) begin
            wr(5'h04, i);
            rd(5'h04, d); chk("R2 select readback", d, i);
            rd(5'h08, d); chk("R2 base readback", d, 32'h0100_0000 * (i + 1) + 32'h20);
            rd(5'h0C, d); chk("R2 attr readback", d, mk_attr(0, i + 3, i, i & 1, 1, 0, 1, i));
        end

        // ---- R3 size sweep on region 0, unprivileged reads, no default map
        wr(5'h00, 32'h1);
        for (int s = 0; s <= 14; s++) begin
            longint sz;
            logic [31:0] eb;
            sz = longint'(1) << ((s < 4 ? 4 : s) + 1);
            eb = (32'h4000_0000 | 32'h0000_5ABC) & ~(32'(sz) - 32'd1);
            sel_base_attr(0, 32'h4000_5ABC, mk_attr(1, s, 3, 0, 0, 0, 0, 0));
            acc(eb, 1'b0, 1'b0, 1'b0);
            chk($sformatf("R3 first byte s=%0d", s), {rsp_hit, rsp_grant}, 2'b11);
            acc(eb + 32'(sz) - 32'd1, 1'b0, 1'b0, 1'b0);
            chk($sformatf("R3 last byte s=%0d", s), {rsp_hit, rsp_grant}, 2'b11);
            acc(eb - 32'd1, 1'b0, 1'b0, 1'b0);
            chk($sformatf("R3 below s=%0d", s), {rsp_hit, rsp_fault}, 2'b01);
            acc(eb + 32'(sz), 1'b0, 1'b0, 1'b0);
            chk($sformatf("R3 above s=%0d", s), {rsp_hit, rsp_fault}, 2'b01);
        end
        sel_base_attr(0, 32'h4000_0000, mk_attr(1, 31, 3, 0, 0, 0, 0, 0));
        acc(32'h0000_0000, 1'b0, 1'b0, 1'b0); chk("R3 whole map low", rsp_hit, 1);
        acc(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0); chk("R3 whole map high", rsp_hit, 1);

        // ---- R5 / R6 permission sweep on region 1 (4 KiB at 0x2000_0000)
        wr(5'h04, 0); wr(5'h0C, 0);
        for (int ap = 0; ap < 8; ap++) begin
            for (int xn = 0; xn < 2; xn++) begin
                sel_base_attr(1, 32'h2000_0000, mk_attr(1, 11, ap, xn, 0, 0, 0, 0));
                for (int p = 0; p < 2; p++) begin
                    for (int k = 0; k < 3; k++) begin
                        bit ex;
                        ex = (k == 2) ? (xn == 0 && ap_ok(ap, p[0], 1'b0)) : ap_ok(ap, p[0], k == 1);
                        acc(32'h2000_0400, k == 1, k == 2, p[0]);
                        chk($sformatf("%s ap=%0d xn=%0d priv=%0d kind=%0d",
                                      (k == 2 && xn == 1) ? "R6" : "R5", ap, xn, p, k),
                            {rsp_valid, rsp_grant, rsp_fault}, {1'b1, ex, ~ex});
                    end
                end
            end
        end
        // ---- R8 disabled checker grants what the region forbids
        sel_base_attr(1, 32'h2000_0000, mk_attr(1, 11, 0, 1, 0, 0, 0, 0));
        wr(5'h00, 32'h0);
        acc(32'h2000_0400, 1'b1, 1'b0, 1'b0);
        chk("R8 disabled grant", {rsp_grant, rsp_hit}, 2'b10);
        acc(32'h2000_0400, 1'b0, 1'b1, 1'b0);
        chk("R8 disabled fetch", rsp_grant, 1);
        wr(5'h0C, 0);

        // ---- R4 / R7 every enable subset over one address
        wr(5'h00, 32'h1);
        for (int m = 0; m < 256; m++) begin
            int top;
            top = -1;
            for (int i = 0; i < NR; i++) begin
                sel_base_attr(i, 32'h3000_0000, mk_attr(m[i], 4 + i, 3, 0, i & 1, (i >> 1) & 1, (i >> 2) & 1, i ^ 5));
                if (m[i]) top = i;
            end
            acc(32'h3000_0010, 1'b0, 1'b0, 1'b0);
            if (top < 0) begin
                chk($sformatf("R4 none m=%0d", m), {rsp_hit, rsp_fault}, 2'b01);
                chk($sformatf("R7 zero attr m=%0d", m), {rsp_s, rsp_c, rsp_b, rsp_tex}, 6'd0);
            end else begin
                chk($sformatf("R4 winner m=%0d", m), {rsp_hit, rsp_grant, 5'(rsp_region)}, {2'b11, 5'(top)});
                chk($sformatf("R7 attr m=%0d", m), {rsp_s, rsp_c, rsp_b, rsp_tex},
                    {top[0], top[1], top[2], 3'(top ^ 5)});
            end
        end
        for (int i = 0; i < NR; i++) begin
            wr(5'h04, i); wr(5'h0C, 0);
        end

        // ---- R9 default map matrix, no region enabled
        for (int en = 0; en < 2; en++)
            for (int df = 0; df < 2; df++)
                for (int p = 0; p < 2; p++) begin
                    bit ex;
                    ex = (en == 0) || (p == 1 && df == 1);
                    wr(5'h00, {30'd0, df[0], en[0]});
                    acc(32'h5000_0000, 1'b1, 1'b0, p[0]);
                    chk($sformatf("R9 en=%0d dflt=%0d priv=%0d", en, df, p),
                        {rsp_grant, rsp_fault, rsp_hit}, {ex, ~ex, 1'b0});
                end
        @(negedge clk);
        chk("R10 idle after response", rsp_valid, 0);

        // ---- R11 rejected register accesses
        wr(5'h04, 3);
        cfg_op(1'b1, 5'h05, 2'd2, 32'd7, d, e); chk("R11 misaligned err", e, 1);
        cfg_op(1'b1, 5'h04, 2'd0, 32'd6, d, e); chk("R11 byte err", e, 1);
        cfg_op(1'b1, 5'h04, 2'd1, 32'd5, d, e); chk("R11 half err", e, 1);
        cfg_op(1'b1, 5'h18, 2'd2, 32'd4, d, e); chk("R11 hole err", e, 1);
        cfg_op(1'b0, 5'h1C, 2'd2, 32'd0, d, e); chk("R11 hole read err", e, 1);
        cfg_op(1'b0, 5'h04, 2'd2, 32'd0, d, e);
        chk("R11 select kept", d, 3);
        chk("R11 good access no err", e, 0);

        // ---- R12 fault capture
        wr(5'h00, 32'h1);
        wr(5'h10, 0);
        rd(5'h10, d); chk("R12 cleared", d, 0);
        acc(32'h1234_5678, 1'b0, 1'b0, 1'b0);
        rd(5'h10, d); chk("R12 pending", d, 1);
        rd(5'h14, d); chk("R12 first addr", d, 32'h1234_5678);
        acc(32'hAAAA_0000, 1'b0, 1'b0, 1'b0);
        rd(5'h14, d); chk("R12 addr held", d, 32'h1234_5678);
        wr(5'h10, 0);
        rd(5'h10, d2); chk("R12 clear", d2, 0);
        acc(32'hBBBB_0004, 1'b1, 1'b0, 1'b0);
        rd(5'h14, d); chk("R12 new addr", d, 32'hBBBB_0004);

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule